// File: doc/BRIEF.md
# Clock Synthesizer Divider and Ratio Select

This block is the digital half of a frequency synthesizer. The analog phase detector, charge pump, loop filter and VCO sit outside it. A reference divider, clocked by the reference clock, and a feedback divider, clocked by the VCO, each send a one-cycle terminal-count pulse to the external phase detector. When the loop is locked, the VCO therefore runs at the reference frequency times N/M.

A post divider on the VCO side produces the main clock (called 2X) at VCO/C. A further halving produces the 1X clock. The overall ratio from reference to 2X is N/(M·C). A 4-bit select code picks one of sixteen fixed (M, N, C) sets from an internal table.

Two per-output enables put the clock pins into high impedance. An active-low sleep input stops all counting and holds every output low. The block has no data stream, so there is no valid/ready handshake. All inputs are plain level controls and are sampled into each clock domain.

Top module: `clksynth_divsel`

## Requirements
- R1: The select code (`freq_sel[3]` is the MSB) indexes a 16-entry table, giving the 2X/reference factor for each code:
  - As (M, N, C, factor) for codes 0 to 7: 0→(17,95,1, 95/17); 1→(23,107,1, 107/23); 2→(10,35,1, 35/10); 3→(17,95,2, 95/34); 4→(8,56,1, 56/8); 5→(23,107,2, 107/46); 6→(17,38,1, 38/17); 7→(10,35,2, 35/20).
  - For codes 8 to 15: 8→(17,76,1, 76/17); 9→(5,10,1, 2); 10→(5,15,1, 3); 11→(5,40,1, 8); 12→(5,5,2, 1/2); 13→(5,5,4, 1/4); 14→(13,109,1, 109/13); 15→(13,118,1, 118/13).
- R2: `ref_pulse` is high for exactly one `ref_clk` cycle in every M cycles.
- R3: `fb_pulse` is high for exactly one `vco_clk` cycle in every N cycles.
- R4: When C is 2 or 4, `clk2x_out` is a square wave with a period of C `vco_clk` cycles and C/2 cycles high. When C is 1, it follows `vco_clk` directly.
- R5: `clk1x_out` is a square wave with a period of 2·C `vco_clk` cycles and C cycles high. It changes only on rising `vco_clk` edges.
- R6: When `en_2x` or `en_1x` is low, the matching output is high impedance. The enables have no effect on the two pulses or on the other output.
- R7: The select code passes through a two-flop synchronizer in each clock domain. A divider takes a new value only at its own terminal count, so every pulse interval equals the old or the new divide value and is never shorter than 5.
- R8: `sleep_n` is synchronized by two flops per domain. While it is low, every counter holds, both pulses stay low, and both enabled clocks stay low. When it goes high again, counting resumes with the same ratio.
- R9: While `rst` is high, it clears all counters and holds both pulses and the 1X clock low. `rst` is synchronous and must be held for at least three cycles of each clock.
- R10: During reset the select synchronizers preset to 1111, the value an open select bus reads through its pull-ups. The first reference interval after reset is therefore 13 cycles whatever `freq_sel` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| vco_clk | input | 1 | VCO clock from the analog loop |
| rst | input | 1 | Synchronous reset, active high |
| freq_sel | input | 4 | Ratio table index |
| sleep_n | input | 1 | Power-down, active low |
| en_2x | input | 1 | 2X output enable, active high |
| en_1x | input | 1 | 1X output enable, active high |
| ref_pulse | output | 1 | Reference terminal-count pulse to the phase detector |
| fb_pulse | output | 1 | Feedback terminal-count pulse to the phase detector |
| clk2x_out | output | 1 | Main synthesized clock, high impedance when disabled |
| clk1x_out | output | 1 | Half-rate clock, high impedance when disabled |

## Verification
The hardest state to reach from the ports is the gap between reset and the first terminal count. In that window the divider still runs the entry preset by reset, while a different select code is already moving through the synchronizer.

The bench holds the select at 0 through reset. It then times the first reference interval (13) and the one after it (17), which shows that the new value was taken only at the terminal count.

It then changes the select across all sixteen codes while a monitor watches every reference interval for a short one. For each code it measures M, N and the clock periods, and cross-multiplies them against the listed factor.

// File: rtl/clksynth_pkg.sv
package clksynth_pkg;
  localparam int SEL_W  = 4;
  localparam int DIV_W  = 8;
  localparam int POST_W = 3;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic [DIV_W-1:0]  ref_div;
    logic [DIV_W-1:0]  fb_div;
    logic [POST_W-1:0] post_div;
  } ratio_t;

  function automatic ratio_t mk(input int m, input int n, input int c);
    ratio_t r;
    r.ref_div  = DIV_W'(m);
    r.fb_div   = DIV_W'(n);
    r.post_div = POST_W'(c);
    return r;
  endfunction

  function automatic ratio_t ratio_lookup(input logic [SEL_W-1:0] code);
    ratio_t r;
    case (code)
      4'd0:    r = mk(17,  95, 1);
      4'd1:    r = mk(23, 107, 1);
      4'd2:    r = mk(10,  35, 1);
      4'd3:    r = mk(17,  95, 2);
      4'd4:    r = mk( 8,  56, 1);
      4'd5:    r = mk(23, 107, 2);
      4'd6:    r = mk(17,  38, 1);
      4'd7:    r = mk(10,  35, 2);
      4'd8:    r = mk(17,  76, 1);
      4'd9:    r = mk( 5,  10, 1);
      4'd10:   r = mk( 5,  15, 1);
      4'd11:   r = mk( 5,  40, 1);
      4'd12:   r = mk( 5,   5, 2);
      4'd13:   r = mk( 5,   5, 4);
      4'd14:   r = mk(13, 109, 1);
      default: r = mk(13, 118, 1);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/clksynth_sync.sv
module clksynth_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= RST_VAL;
      else     stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/clksynth_tcdiv.sv
module clksynth_tcdiv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] div_next,
  output logic         tc_pulse
);
  logic [W-1:0] cnt;
  logic [W-1:0] div_q;
  logic         at_tc;

  assign at_tc = (cnt == div_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      div_q    <= div_next;
      tc_pulse <= 1'b0;
    end else if (!run) begin
      tc_pulse <= 1'b0;
    end else begin
      tc_pulse <= at_tc;
      if (at_tc) begin
        cnt   <= '0;
        div_q <= div_next;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2 (and R3 for the feedback instance): counter stays inside the window
  assert_cnt_below_div_R2: assert property (@(posedge clk) disable iff (rst)
    cnt < div_q);
  // R2/R3: a pulse lasts a single cycle
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |=> !tc_pulse);
  // R7: divide value changes only at a terminal count
  assert_load_at_tc_R7: assert property (@(posedge clk) disable iff (rst)
    !(run && at_tc) |=> $stable(div_q));
  // R8: no pulse while halted
  assert_halt_no_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> !tc_pulse);
endmodule

// File: rtl/clksynth_postdiv.sv
module clksynth_postdiv #(
  parameter int POST_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [POST_W-1:0] c_next,
  output logic              one_x,
  output logic              two_x
);
  logic [POST_W:0]   cnt, cnt_nx, span;
  logic [POST_W-1:0] c_q, c_nx;
  logic              x1, x2, pass;

  assign span = {c_q, 1'b0};
  assign pass = (c_q == POST_W'(1));

  always_comb begin
    if (cnt == span - 1'b1) begin
      cnt_nx = '0;
      c_nx   = c_next;
    end else begin
      cnt_nx = cnt + 1'b1;
      c_nx   = c_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      c_q <= c_next;
      x1  <= 1'b0;
      x2  <= 1'b0;
    end else if (!run) begin
      x1 <= 1'b0;
      x2 <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      c_q <= c_nx;
      x1  <= (cnt_nx < {1'b0, c_nx});
      x2  <= ((cnt_nx[POST_W-1:0] & (c_nx - 1'b1)) < (c_nx >> 1));
    end
  end

  assign one_x = x1;
  assign two_x = pass ? (clk & run) : x2;

  // R5: phase counter stays inside one 1X period
  assert_cnt_in_window_R5: assert property (@(posedge clk) disable iff (rst)
    cnt < span);
  // R7: post-divide value changes only at the end of a 1X period
  assert_post_load_R7: assert property (@(posedge clk) disable iff (rst)
    !(run && cnt == span - 1'b1) |=> $stable(c_q));
  // R8: both clocks low while halted
  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!x1 && !x2));
endmodule

// File: rtl/clksynth_divsel.sv
module clksynth_divsel
  import clksynth_pkg::*;
(
  input  logic             ref_clk,
  input  logic             vco_clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] freq_sel,
  input  logic             sleep_n,
  input  logic             en_2x,
  input  logic             en_1x,
  output logic             ref_pulse,
  output logic             fb_pulse,
  output logic             clk2x_out,
  output logic             clk1x_out
);
  localparam logic [SEL_W-1:0] OPEN_SEL = '1;

  logic [SEL_W-1:0] sel_ref, sel_vco;
  logic             run_ref, run_vco;
  ratio_t           r_ref, r_vco;
  logic             one_x, two_x;

  clksynth_sync #(.W(SEL_W), .STAGES(SYNC_STAGES), .RST_VAL(OPEN_SEL)) u_sel_ref (
    .clk(ref_clk), .rst(rst), .d(freq_sel), .q(sel_ref));
  clksynth_sync #(.W(SEL_W), .STAGES(SYNC_STAGES), .RST_VAL(OPEN_SEL)) u_sel_vco (
    .clk(vco_clk), .rst(rst), .d(freq_sel), .q(sel_vco));
  clksynth_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_run_ref (
    .clk(ref_clk), .rst(rst), .d(sleep_n), .q(run_ref));
  clksynth_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_run_vco (
    .clk(vco_clk), .rst(rst), .d(sleep_n), .q(run_vco));

  assign r_ref = ratio_lookup(sel_ref);
  assign r_vco = ratio_lookup(sel_vco);

  clksynth_tcdiv #(.W(DIV_W)) u_ref_div (
    .clk(ref_clk), .rst(rst), .run(run_ref),
    .div_next(r_ref.ref_div), .tc_pulse(ref_pulse));

  clksynth_tcdiv #(.W(DIV_W)) u_fb_div (
    .clk(vco_clk), .rst(rst), .run(run_vco),
    .div_next(r_vco.fb_div), .tc_pulse(fb_pulse));

  clksynth_postdiv #(.POST_W(POST_W)) u_post (
    .clk(vco_clk), .rst(rst), .run(run_vco),
    .c_next(r_vco.post_div), .one_x(one_x), .two_x(two_x));

  assign clk2x_out = en_2x ? two_x : 1'bz;
  assign clk1x_out = en_1x ? one_x : 1'bz;

  // R1: every table entry keeps both dividers in range and C in {1,2,4}
  assert_table_legal_R1: assert property (@(posedge ref_clk) disable iff (rst)
    (r_ref.ref_div >= DIV_W'(5)) && (r_ref.ref_div <= DIV_W'(128)) &&
    $onehot(r_ref.post_div) && !r_ref.post_div[0] == (r_ref.post_div != POST_W'(1)));
endmodule

// File: tb/sim_clksynth_divsel.sv
module sim_clksynth_divsel;
  localparam int CLK_PERIOD = 10;
  localparam int VCO_PERIOD = 4;

  logic ref_clk = 1'b0, vco_clk = 1'b0;
  logic rst = 1'b1, sleep_n = 1'b1, en_2x = 1'b1, en_1x = 1'b1;
  logic [3:0] sel = 4'd0;
  wire ref_pulse, fb_pulse, clk2x_out, clk1x_out;

  int checks = 0, errors = 0, runts = 0, gap = 0;
  bit armed = 1'b0, gap_valid = 1'b0, done = 1'b0;

  clksynth_divsel u0 (
    .ref_clk(ref_clk), .vco_clk(vco_clk), .rst(rst), .freq_sel(sel),
    .sleep_n(sleep_n), .en_2x(en_2x), .en_1x(en_1x),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .clk2x_out(clk2x_out), .clk1x_out(clk1x_out));

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
  always #(VCO_PERIOD/2) vco_clk = ~vco_clk;

  // R1 table as stated: M, N, C and the factor fn/fd
  function automatic int exp_m(int s);
    int t[16] = '{17,23,10,17,8,23,17,10,17,5,5,5,5,5,13,13};
    return t[s];
  endfunction
  function automatic int exp_n(int s);
    int t[16] = '{95,107,35,95,56,107,38,35,76,10,15,40,5,5,109,118};
    return t[s];
  endfunction
  function automatic int exp_c(int s);
    int t[16] = '{1,1,1,2,1,2,1,2,1,1,1,1,2,4,1,1};
    return t[s];
  endfunction
  function automatic int fac_n(int s);
    int t[16] = '{95,107,35,95,56,107,38,35,76,2,3,8,1,1,109,118};
    return t[s];
  endfunction
  function automatic int fac_d(int s);
    int t[16] = '{17,23,10,34,8,46,17,20,17,1,1,1,2,4,13,13};
    return t[s];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ref_gap(output int n);
    int g = 0;
    n = 0;
    do begin @(negedge ref_clk); g++; end while (ref_pulse !== 1'b1 && g < 400);
    do begin @(negedge ref_clk); n++; end while (ref_pulse !== 1'b1 && n < 400);
  endtask

  task automatic fb_gap(output int n);
    int g = 0;
    n = 0;
    do begin @(negedge vco_clk); g++; end while (fb_pulse !== 1'b1 && g < 400);
    do begin @(negedge vco_clk); n++; end while (fb_pulse !== 1'b1 && n < 400);
  endtask

  function automatic logic smp(bit two);
    return two ? clk2x_out : clk1x_out;
  endfunction

  task automatic runs(input bit two, output int hi, output int lo);
    int g = 0;
    hi = 0; lo = 0;
    do begin @(negedge vco_clk); g++; end while (smp(two) !== 1'b0 && g < 100);
    do begin @(negedge vco_clk); g++; end while (smp(two) !== 1'b1 && g < 200);
    while (smp(two) === 1'b1 && hi < 100) begin hi++; @(negedge vco_clk); end
    while (smp(two) === 1'b0 && lo < 100) begin lo++; @(negedge vco_clk); end
  endtask

  // R7 monitor: no reference interval shorter than the smallest divide value
  always @(negedge ref_clk) begin
    if (armed) begin
      if (ref_pulse === 1'b1) begin
        if (gap_valid && gap + 1 < 5) runts++;
        gap = 0;
        gap_valid = 1'b1;
      end else begin
        gap++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, m, hi, lo, c2, bad, hits;
    repeat (6) @(negedge ref_clk);
    // R9: reset state
    chk("R9 ref_pulse in reset", int'(ref_pulse === 1'b0), 1);
    chk("R9 fb_pulse in reset", int'(fb_pulse === 1'b0), 1);
    chk("R9 clk1x in reset", int'(clk1x_out === 1'b0), 1);
    rst = 1'b0;
    n = 0;
    do begin @(negedge ref_clk); n++; end while (ref_pulse !== 1'b1 && n < 400);
    chk("R10 first interval uses open-bus entry", n, 13);
    m = 0;
    do begin @(negedge ref_clk); m++; end while (ref_pulse !== 1'b1 && m < 400);
    chk("R7 next interval takes new code at terminal count", m, 17);
    armed = 1'b1;

    for (int s = 0; s < 16; s++) begin
      sel = 4'(s);
      repeat (4) @(negedge ref_clk);
      ref_gap(m); ref_gap(m);
      chk($sformatf("R2 ref period sel=%0d", s), m, exp_m(s));
      fb_gap(n); fb_gap(n);
      chk($sformatf("R3 fb period sel=%0d", s), n, exp_n(s));
      runs(1'b0, hi, lo); runs(1'b0, hi, lo);
      chk($sformatf("R5 1x high sel=%0d", s), hi, exp_c(s));
      chk($sformatf("R5 1x low sel=%0d", s), lo, exp_c(s));
      if (exp_c(s) == 1) begin
        @(posedge vco_clk); #1;
        chk($sformatf("R4 2x follows vco high sel=%0d", s), int'(clk2x_out === 1'b1), 1);
        @(negedge vco_clk); #1;
        chk($sformatf("R4 2x follows vco low sel=%0d", s), int'(clk2x_out === 1'b0), 1);
        c2 = 1;
      end else begin
        runs(1'b1, hi, lo);
        chk($sformatf("R4 2x high sel=%0d", s), hi, exp_c(s) / 2);
        chk($sformatf("R4 2x low sel=%0d", s), lo, exp_c(s) / 2);
        c2 = hi + lo;
      end
      // R1: measured N/(M*C) equals the listed factor
      chk($sformatf("R1 factor sel=%0d", s), n * fac_d(s), fac_n(s) * m * c2);
    end
    chk("R7 no short reference interval", runts, 0);

    // R6: enables
    en_1x = 1'b0;
    @(negedge vco_clk);
    chk("R6 1x high impedance", int'(clk1x_out === 1'bz), 1);
    runs(1'b1, hi, lo);
    chk("R6 2x unaffected by en_1x", int'(clk2x_out !== 1'bz), 1);
    en_2x = 1'b0;
    @(negedge vco_clk);
    chk("R6 2x high impedance", int'(clk2x_out === 1'bz), 1);
    fb_gap(n);
    chk("R6 fb pulse unaffected by enables", n, 118);
    en_1x = 1'b1; en_2x = 1'b1;

    // R8: power-down on entry 13 (C=4)
    sel = 4'd13;
    repeat (4) @(negedge ref_clk);
    ref_gap(m); ref_gap(m);
    sleep_n = 1'b0;
    repeat (4) @(negedge ref_clk);
    bad = 0; hits = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge vco_clk);
      if (fb_pulse !== 1'b0 || clk1x_out !== 1'b0 || clk2x_out !== 1'b0) bad++;
      if (i % 3 == 0 && ref_pulse !== 1'b0) hits++;
    end
    chk("R8 vco side quiet while asleep", bad, 0);
    chk("R8 ref pulse quiet while asleep", hits, 0);
    sleep_n = 1'b1;
    ref_gap(m); ref_gap(m);
    chk("R8 ref period after wake", m, 5);
    runs(1'b1, hi, lo);
    chk("R8 2x high after wake", hi, 2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule